// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailboxes

This block is a two-port word memory shared by two agents, called left and right. Each side has its own enable, write strobe, output enable, two byte-lane selects, address and data, so both sides can read or write any word in the same clock cycle. Access is synchronous: a write commits at the clock edge, and read data appears on the cycle after the request.

The two top words also serve as mailboxes for signalling between the sides. The highest word belongs to the right side and the word just below it belongs to the left side. When one side writes into the other side's mailbox, the owner's active-low interrupt output asserts. The interrupt clears when the owner reads its own mailbox. The stored value is ordinary data and has no meaning to the block.

Top module: `dpram_mbox`

## Requirements
- R1: A write happens in a cycle where en=1, wr=1 and at least one lane select is 1. The upper select (ub) gates bits DATA_W-1..DATA_W/2 and the lower select (lb) gates bits DATA_W/2-1..0. Lanes that are not selected keep their old contents.
- R2: A read happens in a cycle where en=1, wr=0 and oe=1. On the next cycle, rdata shows the addressed word with unselected lanes forced to 0. In any cycle that follows a cycle without a read, rdata is all zeros.
- R3: If one side writes a word that the other side reads in the same cycle, the reader gets the old value. The new value is visible from the next cycle onward.
- R4: If both sides write the same word in the same cycle, the left side's data wins on every lane it selects. The right side's data lands only on lanes that the left side did not select.
- R5: A left-side write to the highest address (all address bits 1) drives r_int_n to 0 on the following cycle.
- R6: A right-side write to the second-highest address (all bits 1 except bit 0) drives l_int_n to 0 on the following cycle.
- R7: A read by a side of its own mailbox releases that side's interrupt (output back to 1) on the following cycle.
- R8: A side writing its own mailbox, or reading the other side's mailbox, does not change either interrupt. With no posting write and no owner read, an interrupt holds its value.
- R9: If a posting write and the owner's clearing read hit the same mailbox in the same cycle, the interrupt ends asserted.
- R10: After reset, both interrupt outputs are 1 and both rdata buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left enable |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper lane select |
| l_lb | input | 1 | Left lower lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_en | input | 1 | Right enable |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper lane select |
| r_lb | input | 1 | Right lower lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The interrupt assertions rely only on the decoded posting-write and owner-read events. They assume the control inputs are known (never X) on every clock edge after reset, and they allow any mix of operations on both sides in the same cycle. The stimulus sets every control input to a defined value on each cycle. Half of the random addresses fall on the top four words, so that mailbox posts, owner reads, self-writes and clashes on one address occur often. Directed cycles also cover same-cycle post-and-clear and both sides writing one word.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // index of each side inside the per-side arrays
  typedef enum int {SIDE_L = 0, SIDE_R = 1} side_e;
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              en,
  input  logic              wr,
  input  logic              oe,
  input  logic              ub,
  input  logic              lb,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_go,
  output logic              rd_go,
  output logic              at_top,
  output logic              at_next,
  output logic [DATA_W-1:0] lane_m
);
  localparam int HALF = DATA_W / 2;
  localparam logic [ADDR_W-1:0] TOP_A  = '1;
  localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

  // upper lane covers bits DATA_W-1..HALF, lower lane HALF-1..0
  function automatic logic [DATA_W-1:0] lane_mask(input logic u, input logic l);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= HALF) ? u : l;
    return m;
  endfunction

  assign lane_m  = lane_mask(ub, lb);
  assign wr_go   = en & wr & (ub | lb);
  assign rd_go   = en & ~wr & oe;
  assign at_top  = (addr == TOP_A);
  assign at_next = (addr == NEXT_A);
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             wr,
  input  logic [1:0]             rd,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic [1:0][DATA_W-1:0] mask,
  output logic [1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              same_word;
  logic [DATA_W-1:0] r_eff;

  // left lanes take precedence when both sides write one word
  assign same_word = wr[0] & wr[1] & (addr[0] == addr[1]);
  assign r_eff     = same_word ? (mask[1] & ~mask[0]) : mask[1];

  always_ff @(posedge clk) begin
    if (same_word) begin
      mem[addr[0]] <= (mem[addr[0]] & ~(mask[0] | r_eff))
                    | (wdata[0] & mask[0]) | (wdata[1] & r_eff);
    end else begin
      if (wr[0]) mem[addr[0]] <= (mem[addr[0]] & ~mask[0]) | (wdata[0] & mask[0]);
      if (wr[1]) mem[addr[1]] <= (mem[addr[1]] & ~mask[1]) | (wdata[1] & mask[1]);
    end
  end

  // reads see the word as it was before this edge's writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      for (int p = 0; p < 2; p++)
        rdata[p] <= rd[p] ? (mem[addr[p]] & mask[p]) : '0;
    end
  end

  // R2
  l_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd[0] |=> (rdata[0] == '0));
  // R2
  r_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd[1] |=> (rdata[1] == '0));
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wr_go,
  input  logic [1:0] rd_go,
  input  logic [1:0] at_top,
  input  logic [1:0] at_next,
  output logic       l_int_n,
  output logic       r_int_n
);
  logic l_flag, r_flag;
  logic l_post_r, r_take_r, r_post_l, l_take_l;

  // left posts to right box (top word), right drains it
  assign l_post_r = wr_go[0] & at_top[0];
  assign r_take_r = rd_go[1] & at_top[1];
  // right posts to left box (word below top), left drains it
  assign r_post_l = wr_go[1] & at_next[1];
  assign l_take_l = rd_go[0] & at_next[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (l_post_r)      r_flag <= 1'b1;
      else if (r_take_r) r_flag <= 1'b0;
      if (r_post_l)      l_flag <= 1'b1;
      else if (l_take_l) l_flag <= 1'b0;
    end
  end

  assign l_int_n = ~l_flag;
  assign r_int_n = ~r_flag;

  // R5
  r_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_post_r |=> !r_int_n);
  // R6
  l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_post_l |=> !l_int_n);
  // R7
  r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take_r && !l_post_r) |=> r_int_n);
  // R7
  l_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take_l && !r_post_l) |=> l_int_n);
  // R8
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_post_r && !r_take_r) |=> $stable(r_int_n));
  // R8
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_post_l && !l_take_l) |=> $stable(l_int_n));
endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  import dpram_pkg::*;

  logic [1:0]             en_v, wr_v, oe_v, ub_v, lb_v;
  logic [1:0][ADDR_W-1:0] addr_v;
  logic [1:0][DATA_W-1:0] wdata_v, mask_v, rdata_v;
  logic [1:0]             wr_go, rd_go, at_top, at_next;

  assign en_v[SIDE_L]    = l_en;     assign en_v[SIDE_R]    = r_en;
  assign wr_v[SIDE_L]    = l_wr;     assign wr_v[SIDE_R]    = r_wr;
  assign oe_v[SIDE_L]    = l_oe;     assign oe_v[SIDE_R]    = r_oe;
  assign ub_v[SIDE_L]    = l_ub;     assign ub_v[SIDE_R]    = r_ub;
  assign lb_v[SIDE_L]    = l_lb;     assign lb_v[SIDE_R]    = r_lb;
  assign addr_v[SIDE_L]  = l_addr;   assign addr_v[SIDE_R]  = r_addr;
  assign wdata_v[SIDE_L] = l_wdata;  assign wdata_v[SIDE_R] = r_wdata;

  for (genvar p = 0; p < 2; p++) begin : g_side
    dpram_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .en(en_v[p]), .wr(wr_v[p]), .oe(oe_v[p]), .ub(ub_v[p]), .lb(lb_v[p]),
      .addr(addr_v[p]), .wr_go(wr_go[p]), .rd_go(rd_go[p]),
      .at_top(at_top[p]), .at_next(at_next[p]), .lane_m(mask_v[p])
    );
  end

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(wr_go), .rd(rd_go), .addr(addr_v),
    .wdata(wdata_v), .mask(mask_v), .rdata(rdata_v)
  );

  dpram_mailbox u_mbox (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .at_top(at_top), .at_next(at_next), .l_int_n(l_int_n), .r_int_n(r_int_n)
  );

  assign l_rdata = rdata_v[SIDE_L];
  assign r_rdata = rdata_v[SIDE_R];
endmodule

// File: tb/tb_dpram_mbox.sv
`timescale 1ns/1ps
module tb_dpram_mbox;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] RBOX = '1;
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic le, lw, lo, lu, ll, re, rw, ro, ru, rl;
  logic [AW-1:0] la, ra;
  logic [DW-1:0] lwd, rwd, l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem_m [DEPTH];
  logic lflag = 1'b0, rflag = 1'b0;
  logic [DW-1:0] exp_l = '0, exp_r = '0;

  always #4 clk = ~clk;

  dpram_mbox #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(le), .l_wr(lw), .l_oe(lo), .l_ub(lu), .l_lb(ll), .l_addr(la),
    .l_wdata(lwd), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_en(re), .r_wr(rw), .r_oe(ro), .r_ub(ru), .r_lb(rl), .r_addr(ra),
    .r_wdata(rwd), .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  function automatic logic [DW-1:0] bmask(input logic u, input logic l);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < DW/2) ? l : u;
    return m;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [DW-1:0] m);
    return (old & ~m) | (d & m);
  endfunction

  task automatic check(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one clock of stimulus on both sides, then compare outputs
  task automatic cyc(input logic le_i, lw_i, lo_i, lu_i, ll_i, input logic [AW-1:0] la_i,
                     input logic [DW-1:0] lwd_i,
                     input logic re_i, rw_i, ro_i, ru_i, rl_i, input logic [AW-1:0] ra_i,
                     input logic [DW-1:0] rwd_i, input string tag);
    logic lwr, lrd, rwr, rrd;
    le = le_i; lw = lw_i; lo = lo_i; lu = lu_i; ll = ll_i; la = la_i; lwd = lwd_i;
    re = re_i; rw = rw_i; ro = ro_i; ru = ru_i; rl = rl_i; ra = ra_i; rwd = rwd_i;
    lwr = le_i & lw_i & (lu_i | ll_i);
    rwr = re_i & rw_i & (ru_i | rl_i);
    lrd = le_i & ~lw_i & lo_i;
    rrd = re_i & ~rw_i & ro_i;
    exp_l = lrd ? (mem_m[la_i] & bmask(lu_i, ll_i)) : '0;
    exp_r = rrd ? (mem_m[ra_i] & bmask(ru_i, rl_i)) : '0;
    if (rwr) mem_m[ra_i] = merge(mem_m[ra_i], rwd_i, bmask(ru_i, rl_i));
    if (lwr) mem_m[la_i] = merge(mem_m[la_i], lwd_i, bmask(lu_i, ll_i));
    if (lwr && la_i == RBOX) rflag = 1'b1;
    else if (rrd && ra_i == RBOX) rflag = 1'b0;
    if (rwr && ra_i == LBOX) lflag = 1'b1;
    else if (lrd && la_i == LBOX) lflag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 left rdata"}, l_rdata, exp_l);
    check({tag, " R2 right rdata"}, r_rdata, exp_r);
    check({tag, " R5/R6/R7 left int_n"}, {{(DW-1){1'b0}}, l_int_n}, {{(DW-1){1'b0}}, ~lflag});
    check({tag, " R5/R6/R7 right int_n"}, {{(DW-1){1'b0}}, r_int_n}, {{(DW-1){1'b0}}, ~rflag});
  endtask

  localparam logic [DW-1:0] Z = '0;

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    {le, lw, lo, lu, ll, re, rw, ro, ru, rl} = '0;
    la = '0; ra = '0; lwd = '0; rwd = '0;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 left rdata", l_rdata, '0);
    check("R10 right rdata", r_rdata, '0);
    check("R10 left int_n", {{(DW-1){1'b0}}, l_int_n}, {{(DW-1){1'b0}}, 1'b1});
    check("R10 right int_n", {{(DW-1){1'b0}}, r_int_n}, {{(DW-1){1'b0}}, 1'b1});

    // R1 fill every word from the left, both lanes
    for (int a = 0; a < DEPTH; a++)
      cyc(1,1,0,1,1, AW'(a), DW'(a * 37 + 5), 0,0,0,0,0, '0, Z, "R1 fill");
    cyc(0,0,0,0,0, '0, Z, 1,0,1,1,1, RBOX, Z, "R7 drain after fill");

    // R1 upper lane only
    cyc(1,1,0,1,0, AW'(5), '1, 0,0,0,0,0, '0, Z, "R1 upper-lane write");
    cyc(1,0,1,1,1, AW'(5), Z, 0,0,0,0,0, '0, Z, "R1 readback");
    // R2 oe low, then lower lane only
    cyc(1,0,0,1,1, AW'(5), Z, 1,0,1,0,1, AW'(5), Z, "R2 oe gate and lane mask");
    // R3 write and read one word together
    cyc(1,1,0,1,1, AW'(7), 18'h2A5A5, 1,0,1,1,1, AW'(7), Z, "R3 old data");
    cyc(0,0,0,0,0, '0, Z, 1,0,1,1,1, AW'(7), Z, "R3 new data");
    // R4 both write one word, mixed lanes
    cyc(1,1,0,0,1, AW'(9), 18'h15555, 1,1,0,1,1, AW'(9), 18'h3FFFF, "R4 clash");
    cyc(1,0,1,1,1, AW'(9), Z, 0,0,0,0,0, '0, Z, "R4 readback");
    // R5 post to right box, R7 right drains it
    cyc(1,1,0,1,1, RBOX, 18'h00111, 0,0,0,0,0, '0, Z, "R5 post right");
    cyc(1,0,1,1,1, RBOX, Z, 1,1,0,1,1, RBOX, 18'h00222, "R8 other read and own write");
    cyc(0,0,0,0,0, '0, Z, 1,0,1,1,1, RBOX, Z, "R7 right drain");
    // R6 post to left box, R8 left self-write, R7 left drains it
    cyc(0,0,0,0,0, '0, Z, 1,1,0,1,1, LBOX, 18'h00333, "R6 post left");
    cyc(1,1,0,1,1, LBOX, 18'h00444, 1,0,1,1,1, LBOX, Z, "R8 left self-write");
    cyc(1,0,1,1,1, LBOX, Z, 0,0,0,0,0, '0, Z, "R7 left drain");
    // R9 post and drain in one cycle
    cyc(1,1,0,1,1, RBOX, 18'h00555, 1,0,1,1,1, RBOX, Z, "R9 post wins");
    cyc(0,0,0,0,0, '0, Z, 0,0,0,0,0, '0, Z, "R9 hold");

    // random mix, half on the top four words
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a0, a1;
      a0 = $urandom_range(1) ? AW'(DEPTH - 1 - $urandom_range(3)) : AW'($urandom);
      a1 = $urandom_range(1) ? AW'(DEPTH - 1 - $urandom_range(3)) : AW'($urandom);
      cyc($urandom_range(3) != 0, $urandom_range(1), $urandom_range(3) != 0,
          $urandom_range(3) != 0, $urandom_range(3) != 0, a0, DW'($urandom),
          $urandom_range(3) != 0, $urandom_range(1), $urandom_range(3) != 0,
          $urandom_range(3) != 0, $urandom_range(3) != 0, a1, DW'($urandom),
          "R1 R3 R4 R8 R9 random");
    end

    // R1 final sweep of every word from the right
    for (int a = 0; a < DEPTH; a++)
      cyc(0,0,0,0,0, '0, Z, 1,0,1,1,1, AW'(a), Z, "R1 sweep");
    summary();
  end
endmodule